// File: doc/BRIEF.md
# Configuration Read Token Responder

This block answers register read requests that arrive as a stream of tokens on a channel link. Each token is one byte plus a flag that marks it as a control token, and at most one token moves per clock on each side under a valid/ready handshake. The block reads a request packet and keeps the return destination and the register address it carries. It then reads a small bank of 32-bit configuration registers and sends back a reply packet addressed to that destination.

A request has seven tokens. The first is the control token 0xC1. Three data bytes follow with the 24-bit return identifier, most significant byte first: the upper 16 bits name the node and processor, and the low 8 bits name the channel end. Two data bytes follow with the 16-bit register address, high byte first. The last token is the control token 0x01.

The reply has six tokens: the control token 0x03, the four bytes of the register value with the most significant byte first, and the control token 0x01. The reply is tagged as network 0. While a reply is pending the block holds its input ready low, so only one request is served at a time. The register bank has a plain write port used to load values.

Top module: `cfgrd_read_responder`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A well-formed request on network 0 produces a reply with exactly six tokens: control 0x03, then four data bytes of the addressed register (bits 31..24, 23..16, 15..8, 7..0 in that order), then control 0x01. out_net is 0 on every reply token.
- R3: out_dest carries the 24-bit return identifier, formed as {first, second, third} identifier byte. It stays constant for the whole reply.
- R4: The register address is {first address byte, second address byte}, so the first address byte is the high byte.
- R5: A token that arrives with in_net other than 0 is consumed (in_ready stays high) and has no effect on the parse. A request sent entirely on another network gets no reply, and network-0 tokens of one request may have foreign tokens interleaved between them.
- R6: A packet whose first token is a control token other than 0xC1, or whose seventh token is not control 0x01, produces no reply. The parser returns to idle, and the next well-formed request is served normally.
- R7: An address at or above NREGS reads as 0x00000000, and the reply still starts with the 0x03 acknowledge token.
- R8: in_ready is 0 from the cycle after the closing request token is accepted until the closing reply token has been accepted. While out_valid is 1 and out_ready is 0, out_data, out_ctrl and out_dest hold their values.
- R9: The reply carries the register value as it was when the closing request token was accepted. Writes made later do not change a reply in progress.
- R10: wr_en with wr_addr below NREGS updates that register at the clock edge. A write to an address at or above NREGS changes no register.
- R11: A control token that arrives where an identifier or address byte belongs aborts the packet. That token does not start a new packet, even if it is 0xC1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming token valid |
| in_ready | output | 1 | Incoming token accepted when high together with in_valid |
| in_ctrl | input | 1 | Incoming token is a control token |
| in_data | input | 8 | Incoming token byte |
| in_net | input | NET_W | Network number of the incoming token |
| out_valid | output | 1 | Reply token valid |
| out_ready | input | 1 | Downstream accepts the reply token |
| out_ctrl | output | 1 | Reply token is a control token |
| out_data | output | 8 | Reply token byte |
| out_dest | output | 24 | Return identifier of the current reply |
| out_net | output | NET_W | Network number of the reply, always 0 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Register write address |
| wr_data | input | 32 | Register write value |

## Verification
The bench goes after byte order in both directions. A design that swaps the address bytes reads the wrong register, and one that reverses the value bytes sends them little-endian. It checks abort paths: a data byte where the end token belongs, a wrong opening control code, and a 0xC1 in the middle of a packet. A parser that resynchronises on the stray 0xC1, or that accepts any end token, would send a reply the model does not expect. It also mixes foreign-network tokens into a request, writes the target register during a reply, reads beyond the bank, and stalls out_ready for several cycles. These catch designs that parse foreign tokens, re-read the register late, answer with garbage, or let the output change while stalled.

// File: rtl/cfgrd_pkg.sv
package cfgrd_pkg;
  localparam logic [7:0] TOK_READ = 8'hC1;
  localparam logic [7:0] TOK_ACK  = 8'h03;
  localparam logic [7:0] TOK_END  = 8'h01;

  localparam int unsigned ID_BYTES   = 3;
  localparam int unsigned ADDR_BYTES = 2;
  localparam int unsigned DEST_W     = 8 * ID_BYTES;
  localparam int unsigned ADDR_W     = 8 * ADDR_BYTES;
  localparam int unsigned WORD_W     = 32;

  typedef enum logic [2:0] {
    P_IDLE,
    P_ID_HI,
    P_ID_MID,
    P_ID_LO,
    P_ADDR_HI,
    P_ADDR_LO,
    P_CLOSE
  } parse_st_t;
endpackage

// File: rtl/cfgrd_parser.sv
module cfgrd_parser
  import cfgrd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_fire,
  input  logic              tok_ctrl,
  input  logic [7:0]        tok_data,
  output logic              req_fire,
  output logic [DEST_W-1:0] req_dest,
  output logic [ADDR_W-1:0] req_addr
);
  parse_st_t         state_q, state_d;
  logic [DEST_W-1:0] dest_q, dest_d;
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    state_d  = state_q;
    dest_d   = dest_q;
    addr_d   = addr_q;
    req_fire = 1'b0;
    if (tok_fire) begin
      case (state_q)
        P_IDLE: begin
          if (tok_ctrl && tok_data == TOK_READ) state_d = P_ID_HI;
        end
        P_ID_HI: begin
          if (tok_ctrl) state_d = P_IDLE;
          else begin
            dest_d[23:16] = tok_data;
            state_d       = P_ID_MID;
          end
        end
        P_ID_MID: begin
          if (tok_ctrl) state_d = P_IDLE;
          else begin
            dest_d[15:8] = tok_data;
            state_d      = P_ID_LO;
          end
        end
        P_ID_LO: begin
          if (tok_ctrl) state_d = P_IDLE;
          else begin
            dest_d[7:0] = tok_data;
            state_d     = P_ADDR_HI;
          end
        end
        P_ADDR_HI: begin
          if (tok_ctrl) state_d = P_IDLE;
          else begin
            addr_d[15:8] = tok_data;
            state_d      = P_ADDR_LO;
          end
        end
        P_ADDR_LO: begin
          if (tok_ctrl) state_d = P_IDLE;
          else begin
            addr_d[7:0] = tok_data;
            state_d     = P_CLOSE;
          end
        end
        P_CLOSE: begin
          state_d = P_IDLE;
          if (tok_ctrl && tok_data == TOK_END) req_fire = 1'b1;
        end
        default: state_d = P_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= P_IDLE;
      dest_q  <= '0;
      addr_q  <= '0;
    end else if (tok_fire) begin
      state_q <= state_d;
      dest_q  <= dest_d;
      addr_q  <= addr_d;
    end
  end

  assign req_dest = dest_q;
  assign req_addr = addr_q;
endmodule

// File: rtl/cfgrd_regbank.sv
module cfgrd_regbank
  import cfgrd_pkg::*;
#(
  parameter int unsigned NREGS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NREGS);

  logic [WORD_W-1:0] regs_q [NREGS];
  logic              wr_hit;

  assign wr_hit = wr_en && ({1'b0, wr_addr} < LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(NREGS); i++) regs_q[i] <= '0;
    end else if (wr_hit) begin
      for (int i = 0; i < int'(NREGS); i++) begin
        if (wr_addr == ADDR_W'(i)) regs_q[i] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < int'(NREGS); i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data = regs_q[i];
    end
  end
endmodule

// File: rtl/cfgrd_emitter.sv
module cfgrd_emitter
  import cfgrd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DEST_W-1:0] load_dest,
  input  logic [WORD_W-1:0] load_word,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              out_ctrl,
  output logic [7:0]        out_data,
  output logic [DEST_W-1:0] out_dest,
  output logic              busy
);
  localparam int unsigned NBYTES = WORD_W / 8;
  localparam int unsigned NTOK   = NBYTES + 2;
  localparam int unsigned IDX_W  = $clog2(NTOK);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NTOK - 1);

  logic              busy_q, busy_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [DEST_W-1:0] dest_q, dest_d;
  logic [7:0]        byte_arr [NBYTES];
  logic [7:0]        body_byte;

  for (genvar b = 0; b < int'(NBYTES); b++) begin : g_slice
    assign byte_arr[b] = word_q[WORD_W-1-8*b -: 8];
  end

  always_comb begin
    body_byte = '0;
    for (int b = 0; b < int'(NBYTES); b++) begin
      if (idx_q == IDX_W'(b + 1)) body_byte = byte_arr[b];
    end
  end

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    word_d = word_q;
    dest_d = dest_q;
    if (load) begin
      busy_d = 1'b1;
      idx_d  = '0;
      word_d = load_word;
      dest_d = load_dest;
    end else if (busy_q && out_ready) begin
      if (idx_q == LAST) begin
        busy_d = 1'b0;
        idx_d  = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      word_q <= '0;
      dest_q <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      word_q <= word_d;
      dest_q <= dest_d;
    end
  end

  always_comb begin
    out_valid = busy_q;
    out_dest  = dest_q;
    if (idx_q == '0) begin
      out_ctrl = 1'b1;
      out_data = TOK_ACK;
    end else if (idx_q == LAST) begin
      out_ctrl = 1'b1;
      out_data = TOK_END;
    end else begin
      out_ctrl = 1'b0;
      out_data = body_byte;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/cfgrd_read_responder.sv
module cfgrd_read_responder
  import cfgrd_pkg::*;
#(
  parameter int unsigned NREGS = 16,
  parameter int unsigned NET_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_ctrl,
  input  logic [7:0]       in_data,
  input  logic [NET_W-1:0] in_net,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_ctrl,
  output logic [7:0]       out_data,
  output logic [23:0]      out_dest,
  output logic [NET_W-1:0] out_net,
  input  logic             wr_en,
  input  logic [15:0]      wr_addr,
  input  logic [31:0]      wr_data
);
  logic              busy;
  logic              accept;
  logic              tok_fire;
  logic              req_fire;
  logic [DEST_W-1:0] req_dest;
  logic [ADDR_W-1:0] req_addr;
  logic [WORD_W-1:0] rd_word;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign tok_fire = accept && (in_net == '0);
  assign out_net  = '0;

  cfgrd_parser u_parser (
    .clk      (clk),
    .rst_n    (rst_n),
    .tok_fire (tok_fire),
    .tok_ctrl (in_ctrl),
    .tok_data (in_data),
    .req_fire (req_fire),
    .req_dest (req_dest),
    .req_addr (req_addr)
  );

  cfgrd_regbank #(.NREGS(NREGS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (req_addr),
    .rd_data (rd_word)
  );

  cfgrd_emitter u_emit (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (req_fire),
    .load_dest (req_dest),
    .load_word (rd_word),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_ctrl  (out_ctrl),
    .out_data  (out_data),
    .out_dest  (out_dest),
    .busy      (busy)
  );
endmodule

// File: rtl/cfgrd_checker.sv
module cfgrd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        in_ctrl,
  input logic [7:0]  in_data,
  input logic        out_valid,
  input logic        out_ready,
  input logic        out_ctrl,
  input logic [7:0]  out_data,
  input logic [23:0] out_dest
);
  a_r2_ack_leads: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_ctrl && out_data == 8'h03));

  a_r2_end_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_ctrl && out_data == 8'h01) |=> !out_valid);

  a_r8_reply_needs_close: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready && in_ctrl && in_data == 8'h01));

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_ctrl) && $stable(out_dest)));

  a_r3_dest_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> $stable(out_dest));
endmodule

bind cfgrd_read_responder cfgrd_checker u_cfgrd_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_ctrl   (in_ctrl),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_ctrl  (out_ctrl),
  .out_data  (out_data),
  .out_dest  (out_dest)
);

// File: tb/cfgrd_read_responder_tb_top.sv
module cfgrd_read_responder_tb_top;
  localparam int NREGS = 16;
  localparam int NET_W = 4;

  logic             clk;
  logic             rst_n;
  logic             in_valid;
  logic             in_ready;
  logic             in_ctrl;
  logic [7:0]       in_data;
  logic [NET_W-1:0] in_net;
  logic             out_valid;
  logic             out_ready;
  logic             out_ctrl;
  logic [7:0]       out_data;
  logic [23:0]      out_dest;
  logic [NET_W-1:0] out_net;
  logic             wr_en;
  logic [15:0]      wr_addr;
  logic [31:0]      wr_data;

  cfgrd_read_responder #(.NREGS(NREGS), .NET_W(NET_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_ctrl(in_ctrl),
    .in_data(in_data), .in_net(in_net),
    .out_valid(out_valid), .out_ready(out_ready), .out_ctrl(out_ctrl),
    .out_data(out_data), .out_dest(out_dest), .out_net(out_net),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int    n_chk  = 0;
  int    n_fail = 0;
  int    cyc    = 0;
  string tag    = "R1";
  bit    done   = 0;

  // behavioural reference
  logic [31:0] m_bank [NREGS];
  logic [8:0]  m_q [$];
  logic [23:0] m_dest;
  logic [23:0] m_id;
  logic [15:0] m_addr;
  int          m_stage;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      finish_run();
    end
  end

  task automatic check_outputs();
    chk("out_valid", 32'(out_valid), 32'(m_q.size() > 0));
    if (m_q.size() > 0) begin
      chk("out_ctrl", 32'(out_ctrl), 32'(m_q[0][8]));
      chk("out_data", 32'(out_data), 32'(m_q[0][7:0]));
      chk("out_dest", 32'(out_dest), 32'(m_dest));
      chk("out_net", 32'(out_net), 32'(0));
    end
  endtask

  // one clock: compare, drive, predict, advance
  task automatic cycle(bit v, bit c, logic [7:0] d, logic [NET_W-1:0] n, bit ordy,
                       bit we = 0, logic [15:0] wa = 16'h0, logic [31:0] wd = 32'h0);
    bit          rdy_exp;
    logic [31:0] rd;
    check_outputs();
    in_valid = v; in_ctrl = c; in_data = d; in_net = n; out_ready = ordy;
    wr_en = we; wr_addr = wa; wr_data = wd;
    #1;
    rdy_exp = (m_q.size() == 0);
    chk("in_ready", 32'(in_ready), 32'(rdy_exp));
    if (m_q.size() > 0 && ordy) void'(m_q.pop_front());
    if (v && rdy_exp && n == '0) begin
      case (m_stage)
        0: if (c && d == 8'hC1) m_stage = 1;
        1, 2, 3: if (c) m_stage = 0; else begin m_id = {m_id[15:0], d}; m_stage++; end
        4, 5: if (c) m_stage = 0; else begin m_addr = {m_addr[7:0], d}; m_stage++; end
        default: begin
          m_stage = 0;
          if (c && d == 8'h01) begin
            rd = (m_addr < NREGS) ? m_bank[m_addr] : 32'h0;
            m_dest = m_id;
            m_q.push_back({1'b1, 8'h03});
            m_q.push_back({1'b0, rd[31:24]});
            m_q.push_back({1'b0, rd[23:16]});
            m_q.push_back({1'b0, rd[15:8]});
            m_q.push_back({1'b0, rd[7:0]});
            m_q.push_back({1'b1, 8'h01});
          end
        end
      endcase
    end
    if (we && wa < NREGS) m_bank[wa] = wd;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int k, bit ordy = 1);
    for (int i = 0; i < k; i++) cycle(0, 0, 8'h00, '0, ordy);
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    cycle(0, 0, 8'h00, '0, 1, 1, a, d);
  endtask

  task automatic req(logic [23:0] id, logic [15:0] a, logic [NET_W-1:0] n = '0,
                     logic [7:0] close = 8'h01, bit close_ctrl = 1);
    cycle(1, 1, 8'hC1, n, 1);
    cycle(1, 0, id[23:16], n, 1);
    cycle(1, 0, id[15:8], n, 1);
    cycle(1, 0, id[7:0], n, 1);
    cycle(1, 0, a[15:8], n, 1);
    cycle(1, 0, a[7:0], n, 1);
    cycle(1, close_ctrl, close, n, 1);
  endtask

  initial begin
    for (int i = 0; i < NREGS; i++) m_bank[i] = 32'h0;
    m_stage = 0; m_id = '0; m_addr = '0; m_dest = '0;
    rst_n = 0; in_valid = 0; in_ctrl = 0; in_data = 0; in_net = 0;
    out_ready = 1; wr_en = 0; wr_addr = 0; wr_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    tag = "R1";  idle(2);
    tag = "R10"; wr(16'd5, 32'hA1B2C3D4); wr(16'd12, 32'h0F1E2D3C);
    wr(16'd16, 32'hDEADBEEF); wr(16'd15, 32'h55AA00FF);
    tag = "R2";  req(24'h123456, 16'h0005); idle(8);
    tag = "R3";  req(24'hFEDCBA, 16'h000F); idle(8);
    tag = "R4";  req(24'h000001, 16'h000C); idle(8);
    tag = "R7";  req(24'h0A0B0C, 16'h0C00); idle(8);
    tag = "R10"; req(24'h111111, 16'h0010); idle(8);
    tag = "R5";  req(24'h222222, 16'h0005, 4'd3); idle(4);
    cycle(1, 1, 8'hC1, '0, 1); cycle(1, 1, 8'h01, 4'd2, 1);
    cycle(1, 0, 8'h33, '0, 1); cycle(1, 0, 8'h44, '0, 1);
    cycle(1, 0, 8'h99, 4'd7, 1); cycle(1, 0, 8'h55, '0, 1);
    cycle(1, 0, 8'h00, '0, 1); cycle(1, 0, 8'h05, '0, 1);
    cycle(1, 1, 8'h01, '0, 1); idle(8);
    tag = "R6";  req(24'h010203, 16'h0005, '0, 8'h01, 0); idle(3);
    cycle(1, 1, 8'h05, '0, 1); cycle(1, 0, 8'h01, '0, 1); cycle(1, 0, 8'h02, '0, 1);
    cycle(1, 0, 8'h03, '0, 1); cycle(1, 0, 8'h00, '0, 1); cycle(1, 0, 8'h05, '0, 1);
    cycle(1, 1, 8'h01, '0, 1); idle(3);
    req(24'h040506, 16'h0005, '0, 8'h02, 1); idle(3);
    req(24'h070809, 16'h000C); idle(8);
    tag = "R11"; cycle(1, 1, 8'hC1, '0, 1); cycle(1, 0, 8'hAA, '0, 1);
    cycle(1, 1, 8'hC1, '0, 1); cycle(1, 0, 8'hBB, '0, 1); cycle(1, 0, 8'hCC, '0, 1);
    cycle(1, 0, 8'hDD, '0, 1); cycle(1, 0, 8'h00, '0, 1); cycle(1, 0, 8'h05, '0, 1);
    cycle(1, 1, 8'h01, '0, 1); idle(3);
    req(24'hABCDEF, 16'h000F); idle(8);
    tag = "R8";  req(24'h314159, 16'h0005);
    cycle(1, 1, 8'hC1, '0, 0); cycle(1, 0, 8'h11, '0, 0); cycle(0, 0, 8'h00, '0, 0);
    cycle(0, 0, 8'h00, '0, 1); cycle(0, 0, 8'h00, '0, 0); cycle(0, 0, 8'h00, '0, 0);
    for (int i = 0; i < 10; i++) cycle(1, 1, 8'hC1, '0, i[0]);
    idle(8);
    tag = "R9";  req(24'h271828, 16'h000C);
    wr(16'd12, 32'h87654321); wr(16'd12, 32'h13572468); idle(8);
    req(24'h271829, 16'h000C, '0, 8'h01, 1);
    cycle(0, 0, 8'h00, '0, 1, 1, 16'd12, 32'hCAFEF00D); idle(8);
    req(24'h27182A, 16'h000C); idle(8);
    check_outputs();
    done = 1;
    finish_run();
  end
endmodule